// File: doc/BRIEF.md
# Cache Line Refill Read Unit

This unit sits between a cache's miss logic and a slow memory port. When the cache misses, it hands the unit an address and says whether it needs one word or a whole 16-byte line of four words. The unit then issues reads to memory, one word address at a time. Each word that memory returns with an acknowledge goes into a four-entry read FIFO. The FIFO then feeds the cache through a fill strobe that carries the word address and data.

A mode input sets when the cache sees the words. In handshake mode, memory may take any number of cycles per word. The unit holds the whole line in the FIFO and only then releases it as four fill strobes on back-to-back cycles. In burst mode, memory can deliver one word per clock, so each word goes to the cache on the cycle after it arrives. A bus error on any word abandons the refill. The unit then signals an abort, discards any queued words and never marks the line complete. The unit takes no new miss until the current refill has finished or been aborted.

Top module: `lineRefill`

## Requirements
- R1: `missReady` is high only while the unit is idle. A miss is taken only when `missValid` and `missReady` are both high, and `memReq` rises on the next cycle. A `missValid` raised during a refill has no effect on `memAddr`, and no second fetch follows the refill.
- R2: For a quad read (`missQuad`=1), `memAddr` is the miss address with bits 3:0 cleared, plus 4×k for word k. Bits 3:2 count 0,1,2,3, and each step happens on the cycle after an accepted acknowledge. The address holds while no acknowledge arrives.
- R3: For a single read (`missQuad`=0), exactly one word is fetched from the miss address with bits 1:0 cleared. Exactly one fill strobe follows, and it carries that address.
- R4: In handshake mode (`burstMode`=0), no fill strobe appears while `memReq` is high. Fill strobe k appears k+1 cycles after the cycle of the last acknowledge, so all strobes of the line are consecutive.
- R5: In burst mode (`burstMode`=1), the fill strobe for each word appears on the cycle right after the cycle in which that word was acknowledged.
- R6: Fill strobes deliver the words in the order memory returned them. Strobe k carries base+4×k and the k-th acknowledged data word.
- R7: `fillDone` is high together with the last fill strobe of a refill that had no error, and at no other time. `missReady` is high on the next cycle.
- R8: A `memErr` seen while `memReq` is high raises `fillAbort` in that cycle, and the word acknowledged with it is dropped. No fill strobe appears in that cycle or afterwards, `fillDone` never rises for that refill, and the unit is idle on the next cycle.
- R9: `memAck` while the unit is idle is ignored: no fill strobe, no `memReq`, and nothing left behind in the FIFO.
- R10: After reset, `missReady` is 1 and `memReq`, `fillValid`, `fillDone` and `fillAbort` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burstMode | input | 1 | 1 = stream words to the cache as they arrive; 0 = hold the line until all words are in |
| missValid | input | 1 | Cache miss request |
| missAddr | input | 32 | Byte address of the miss |
| missQuad | input | 1 | 1 = four-word line read, 0 = single word read |
| missReady | output | 1 | Unit idle and able to take a miss |
| memReq | output | 1 | Read request to memory |
| memAddr | output | 32 | Word address of the current read |
| memAck | input | 1 | Memory returns a word this cycle |
| memData | input | 32 | Returned word |
| memErr | input | 1 | Bus error on the current read |
| fillValid | output | 1 | Write strobe into the cache |
| fillAddr | output | 32 | Word address of the fill |
| fillData | output | 32 | Fill data |
| fillDone | output | 1 | Last word of a complete refill; the line may be marked valid |
| fillAbort | output | 1 | Refill abandoned because of a bus error |

## Verification
The properties assume that `memAck` and `memErr` carry meaning only while `memReq` is high. They also assume that `burstMode` does not change while a refill is under way. The stimulus drives acknowledges and errors only during fetch. The one exception is a test that pulses `memAck` while the unit is idle to show it is ignored. `burstMode` is set only when a miss is presented. In burst mode, the acknowledges after the first arrive on consecutive cycles, while handshake mode sweeps zero to two idle cycles before each word.

// File: rtl/lineRefillPkg.sv
package lineRefillPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2
  } refillState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch miss address and kind
    logic push;     // accepted memory word into FIFO
    logic pop;      // FIFO head written into the cache
    logic flush;    // bus error: drop everything queued
  } refillStrobes_t;

endpackage

// File: rtl/lineRefillData.sv
module lineRefillData
  import lineRefillPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  refillStrobes_t      stb,
  input  logic [ADDR_W-1:0]   missAddr,
  input  logic                missQuad,
  input  logic [DATA_W-1:0]   memData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [ADDR_W-1:0]   fillAddr,
  output logic [DATA_W-1:0]   fillData,
  output logic                fifoEmpty,
  output logic                fetchLast,
  output logic                fillLast
);

  localparam int IDX_W      = $clog2(LINE_WORDS);
  localparam int LINE_OFF   = IDX_W + 2;
  localparam int FIFO_DEPTH = LINE_WORDS;
  localparam int PTR_W      = $clog2(FIFO_DEPTH);
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

  logic [ADDR_W-1:0] baseAddr;
  logic              quadReg;
  logic [IDX_W-1:0]  fetchIdx, fillIdx;
  logic [IDX_W-1:0]  lastIdx;

  logic [DATA_W-1:0] slots [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  level;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // miss capture and word counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseAddr <= '0;
      quadReg  <= 1'b0;
      fetchIdx <= '0;
      fillIdx  <= '0;
    end else if (stb.capture) begin
      baseAddr <= missQuad ? {missAddr[ADDR_W-1:LINE_OFF], {LINE_OFF{1'b0}}}
                           : {missAddr[ADDR_W-1:2], 2'b00};
      quadReg  <= missQuad;
      fetchIdx <= '0;
      fillIdx  <= '0;
    end else begin
      if (stb.push) fetchIdx <= fetchIdx + 1'b1;
      if (stb.pop)  fillIdx  <= fillIdx + 1'b1;
    end
  end

  // read FIFO
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (stb.push) wrPtr <= nextPtr(wrPtr);
      if (stb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({stb.push, stb.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push) slots[wrPtr] <= memData;
  end

  always_comb begin
    lastIdx   = quadReg ? IDX_W'(LINE_WORDS - 1) : '0;
    memAddr   = baseAddr | ADDR_W'({fetchIdx, 2'b00});
    fillAddr  = baseAddr | ADDR_W'({fillIdx, 2'b00});
    fillData  = slots[rdPtr];
    fifoEmpty = (level == '0);
    fetchLast = (fetchIdx == lastIdx);
    fillLast  = (fillIdx == lastIdx);
  end

endmodule

// File: rtl/lineRefillCtrl.sv
module lineRefillCtrl
  import lineRefillPkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           burstMode,
  input  logic           missValid,
  input  logic           memAck,
  input  logic           memErr,
  input  logic           fifoEmpty,
  input  logic           fetchLast,
  input  logic           fillLast,
  output logic           missReady,
  output logic           memReq,
  output logic           fillValid,
  output logic           fillDone,
  output logic           fillAbort,
  output refillStrobes_t stb
);

  refillState_e state, stateNext;

  always_comb begin
    missReady   = (state == ST_IDLE);
    memReq      = (state == ST_FETCH);
    stb.capture = missReady & missValid;
    stb.flush   = memReq & memErr;
    stb.push    = memReq & memAck & ~memErr;
    stb.pop     = ~fifoEmpty &
                  ((state == ST_DRAIN) | (memReq & burstMode & ~memErr));
    fillValid   = stb.pop;
    fillDone    = stb.pop & fillLast;
    fillAbort   = stb.flush;

    stateNext = state;
    unique case (state)
      ST_IDLE:  if (stb.capture) stateNext = ST_FETCH;
      ST_FETCH: begin
        if (stb.flush)                  stateNext = ST_IDLE;
        else if (stb.push && fetchLast) stateNext = ST_DRAIN;
      end
      ST_DRAIN: if (stb.pop && fillLast) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

endmodule

// File: rtl/lineRefill.sv
module lineRefill
  import lineRefillPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burstMode,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              missQuad,
  output logic              missReady,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData,
  input  logic              memErr,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [DATA_W-1:0] fillData,
  output logic              fillDone,
  output logic              fillAbort
);

  refillStrobes_t stb;
  logic fifoEmpty, fetchLast, fillLast;

  lineRefillCtrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .burstMode (burstMode),
    .missValid (missValid),
    .memAck    (memAck),
    .memErr    (memErr),
    .fifoEmpty (fifoEmpty),
    .fetchLast (fetchLast),
    .fillLast  (fillLast),
    .missReady (missReady),
    .memReq    (memReq),
    .fillValid (fillValid),
    .fillDone  (fillDone),
    .fillAbort (fillAbort),
    .stb       (stb)
  );

  lineRefillData #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LINE_WORDS (LINE_WORDS)
  ) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .missAddr  (missAddr),
    .missQuad  (missQuad),
    .memData   (memData),
    .memAddr   (memAddr),
    .fillAddr  (fillAddr),
    .fillData  (fillData),
    .fifoEmpty (fifoEmpty),
    .fetchLast (fetchLast),
    .fillLast  (fillLast)
  );

endmodule

// File: rtl/lineRefillChk.sv
module lineRefillChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              burstMode,
  input logic              missValid,
  input logic              missReady,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              memErr,
  input logic              fillValid,
  input logic              fillDone,
  input logic              fillAbort
);

  // R1
  accept_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (missValid && missReady) |=> (memReq && !missReady));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck && !memErr) |=> (memReq && $stable(memAddr)));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memAck && !memErr && memAddr[3:2] != 2'b11) |=>
      (!memReq || memAddr[3:2] == 2'($past(memAddr[3:2]) + 2'd1)));

  // R4
  slow_fill_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fillValid && !burstMode) |-> !memReq);

  // R7
  done_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fillDone |-> fillValid);

  // R7
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fillDone |=> missReady);

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fillAbort |-> (!fillValid && !fillDone));

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fillAbort |=> (missReady && !memReq && !fillValid));

endmodule

bind lineRefill lineRefillChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .burstMode (burstMode),
  .missValid (missValid),
  .missReady (missReady),
  .memReq    (memReq),
  .memAddr   (memAddr),
  .memAck    (memAck),
  .memErr    (memErr),
  .fillValid (fillValid),
  .fillDone  (fillDone),
  .fillAbort (fillAbort)
);

// File: tb/lineRefill_tb.sv
`timescale 1ns/1ps
module lineRefill_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        burstMode = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        missQuad = 1'b0;
  logic        missReady, memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic [31:0] memData = '0;
  logic        memErr = 1'b0;
  logic        fillValid;
  logic [31:0] fillAddr, fillData;
  logic        fillDone, fillAbort;

  lineRefill u_dut (
    .clk(clk), .rst_n(rst_n), .burstMode(burstMode),
    .missValid(missValid), .missAddr(missAddr), .missQuad(missQuad),
    .missReady(missReady), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memData(memData), .memErr(memErr),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillData(fillData),
    .fillDone(fillDone), .fillAbort(fillAbort)
  );

  always #10 clk = ~clk;

  int nChk = 0;
  int nBad = 0;
  int cyc  = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          expN = 0;
  logic [31:0] expAddr [4];
  logic [31:0] expData [4];
  int          ackCyc  [4];
  bit          fastMode = 1'b0;
  bit          fillAllowed = 1'b0;
  int          fillCnt = 0;
  int          doneCnt = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wordOf(input logic [31:0] a, input int k);
    return (a ^ 32'h5A5A_0000) + 32'(k) * 32'h0101_0101 + 32'd1;
  endfunction

  // fill monitor, sampled mid-cycle
  always begin
    @(negedge clk);
    #2;
    if (fillValid) begin
      if (!fillAllowed || fillCnt >= expN) begin
        check(1'b0, "R8/R9 unexpected fill strobe", fillAddr, 32'h0);
      end else begin
        int ec;
        ec = fastMode ? ackCyc[fillCnt] + 1 : ackCyc[expN-1] + 1 + fillCnt;
        check(fillAddr == expAddr[fillCnt], "R6 fill address", fillAddr, expAddr[fillCnt]);
        check(fillData == expData[fillCnt], "R6 fill data", fillData, expData[fillCnt]);
        check(cyc == ec, fastMode ? "R5 fill cycle" : "R4 fill cycle", 32'(cyc), 32'(ec));
        check(fillDone == (fillCnt == expN - 1), "R7 done strobe",
              32'(fillDone), 32'(fillCnt == expN - 1));
        fillCnt++;
      end
    end else if (fillDone) begin
      check(1'b0, "R7 done without fill", 32'd1, 32'd0);
    end
    if (fillDone) doneCnt++;
  end

  task automatic runTxn(input bit quad, input bit fast, input logic [31:0] addr,
                        input int gap, input int errAt, input bit poke);
    int n;
    int d0;
    logic [31:0] base;
    n    = quad ? 4 : 1;
    base = quad ? {addr[31:4], 4'h0} : {addr[31:2], 2'b00};
    expN = n; fastMode = fast; fillCnt = 0; fillAllowed = 1'b1;
    for (int k = 0; k < n; k++) begin
      expAddr[k] = base + 32'(4 * k);
      expData[k] = wordOf(addr, k);
    end
    d0 = doneCnt;
    @(negedge clk);
    burstMode = fast; missValid = 1'b1; missAddr = addr; missQuad = quad;
    #1 check(missReady == 1'b1, "R1 ready when idle", 32'(missReady), 32'd1);
    @(negedge clk);
    missValid = 1'b0;
    #1 check(memReq == 1'b1, "R1 fetch starts after accept", 32'(memReq), 32'd1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      memAck = 1'b0; memErr = 1'b0; missValid = 1'b0;
      repeat ((fast && k > 0) ? 0 : gap) @(negedge clk);
      check(memReq == 1'b1, quad ? "R2 request held" : "R3 request held", 32'(memReq), 32'd1);
      check(memAddr == expAddr[k], quad ? "R2 word address" : "R3 single address",
            memAddr, expAddr[k]);
      if (k == errAt) begin
        memAck = 1'b1; memErr = 1'b1; memData = 32'hDEAD_BEEF;
        #1;
        check(fillAbort == 1'b1, "R8 abort strobe", 32'(fillAbort), 32'd1);
        check(fillValid == 1'b0, "R8 no fill on error", 32'(fillValid), 32'd0);
        fillAllowed = 1'b0;
        @(negedge clk);
        memAck = 1'b0; memErr = 1'b0;
        #1;
        check(missReady == 1'b1, "R8 idle after abort", 32'(missReady), 32'd1);
        check(memReq == 1'b0, "R8 request dropped", 32'(memReq), 32'd0);
        repeat (6) @(negedge clk);
        check(doneCnt == d0, "R8 no done after abort", 32'(doneCnt), 32'(d0));
        return;
      end
      memAck = 1'b1; memData = expData[k]; ackCyc[k] = cyc;
      if (poke && k == 1) begin
        missValid = 1'b1; missAddr = addr ^ 32'h0000_0100;
        #1 check(missReady == 1'b0, "R1 busy not ready", 32'(missReady), 32'd0);
      end
    end
    @(negedge clk);
    memAck = 1'b0; missValid = 1'b0;
    for (int w = 0; w < 12 && fillCnt < n; w++) @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
    check(fillCnt == n, quad ? "R6 all words filled" : "R3 one fill", 32'(fillCnt), 32'(n));
    check(doneCnt == d0 + 1, "R7 one done per refill", 32'(doneCnt), 32'(d0 + 1));
    check(missReady == 1'b1, "R7 idle after refill", 32'(missReady), 32'd1);
    check(memReq == 1'b0, "R1 no second fetch", 32'(memReq), 32'd0);
    fillAllowed = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    check(1'b0, "watchdog expired", 32'(cyc), 32'd0);
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    check(missReady == 1'b1, "R10 ready after reset", 32'(missReady), 32'd1);
    check(memReq == 1'b0, "R10 no request after reset", 32'(memReq), 32'd0);
    check(fillValid == 1'b0, "R10 no fill after reset", 32'(fillValid), 32'd0);
    check(fillDone == 1'b0, "R10 no done after reset", 32'(fillDone), 32'd0);
    check(fillAbort == 1'b0, "R10 no abort after reset", 32'(fillAbort), 32'd0);

    // R9 acknowledges while idle
    fillAllowed = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      memAck = 1'b1; memData = 32'hBAD0_0000 + 32'(i);
      #1;
      check(memReq == 1'b0, "R9 idle ack no request", 32'(memReq), 32'd0);
      check(missReady == 1'b1, "R9 idle ack stays ready", 32'(missReady), 32'd1);
    end
    @(negedge clk);
    memAck = 1'b0;
    runTxn(1'b0, 1'b0, 32'h0000_0444, 0, -1, 1'b0);  // R9 no stale word

    // sweep kind x mode x gap x address
    for (int q = 0; q < 2; q++)
      for (int f = 0; f < 2; f++)
        for (int g = 0; g < (f ? 1 : 3); g++)
          for (int a = 0; a < 3; a++)
            runTxn(q[0], f[0], 32'h1000_0000 * a + 32'h0000_0ABC + 32'(a * 7), g, -1, 1'b0);

    // R8 error at every word position
    for (int q = 0; q < 2; q++)
      for (int f = 0; f < 2; f++)
        for (int e = 0; e < (q ? 4 : 1); e++)
          runTxn(q[0], f[0], 32'h2468_ACE0 + 32'(e * 16), f ? 0 : 1, e, 1'b0);

    // R1 miss raised during a refill, then a clean refill
    runTxn(1'b1, 1'b0, 32'h0F0F_0F08, 1, -1, 1'b1);
    runTxn(1'b1, 1'b1, 32'h7000_0010, 0, -1, 1'b1);
    runTxn(1'b1, 1'b0, 32'h3333_3334, 0, -1, 1'b0);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule